// File: doc/BRIEF.md
# Segment Register Load Protection Checker

This block judges one segment-register load against the descriptor already fetched for it. The load names a target class (code, stack, or one of the four data registers), a 16-bit selector, the descriptor's attribute bits, both descriptor table limits, the current privilege level and the processor mode. The block returns either success or exactly one exception vector with a 16-bit error code. Descriptor fetch and the register write are handled elsewhere.

Each load is offered with a one-cycle `valid_i` pulse. The verdict is registered and appears on the following cycle together with a one-cycle `done_o` pulse. Each register class gets its own rule for the exception it raises. The load context (plain load or hardware task switch, legacy or long mode) decides whether privilege and type failures are reported as general protection or as invalid task state.

Top module: `seg_load_checker`

## Requirements
- R1: After reset, and until the first load completes, `done_o`, `fault_o`, `vector_o` and `err_code_o` are all zero.
- R2: A load offered with `valid_i` high on one rising edge gives `done_o` high for exactly the next cycle. With `valid_i` low, `done_o` stays low. A success reports `fault_o`=0, `vector_o`=0 and `err_code_o`=0.
- R3: A selector with index 0 and table bit 0 is null, whatever its RPL. A null selector loaded into the code class (`rclass_i`=0) or the stack class (`rclass_i`=1) raises vector 13 with error code 0, ahead of every other check. A null selector loaded into the data class (`rclass_i`=2 or 3) is accepted, whatever the descriptor bits say.
- R4: A selector is out of range when the last byte of its 8-byte entry lies beyond the selected table limit. That byte is at {sel[15:3],3'b111}. Table bit sel[2]=0 selects `gdt_limit_i` and sel[2]=1 selects `ldt_limit_i`. An out-of-range selector is a protection failure (see R9) and outranks the present check.
- R5: A descriptor with the present bit clear raises vector 11 for the code and data classes and vector 12 for the stack class, in every load context. It outranks all privilege and type checks.
- R6: A code-class load fails when the descriptor is not a code/data descriptor or is not executable. It also fails the privilege check when the segment is conforming and DPL > CPL, or non-conforming and DPL != CPL.
- R7: A stack-class load fails when the descriptor is not a code/data descriptor, is executable, or is not writable. It also fails when DPL != CPL or when the selector RPL (sel[1:0]) != CPL.
- R8: A data-class load fails when the descriptor is not a code/data descriptor or is not readable.
- R9: Failures under R4, R6, R7 and R8 raise vector 13 on a plain load. When `task_sw_i`=1 and `long_mode_i`=0 they raise vector 10 instead. Vector 10 is never reported while `long_mode_i`=1.
- R10: When every load check passes and `stk_limit_fail_i` or `stk_noncanon_i` is set, vector 12 is raised with error code 0.
- R11: For vectors 10, 11, 12 and 13, except the null-selector case of R3 and the stack-status case of R10, the error code is {sel[15:3], sel[2], 2'b00}: the selector with its RPL bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Load offered this cycle |
| rclass_i | input | 2 | Target class: 0 code, 1 stack, 2 or 3 data |
| sel_i | input | 16 | Selector: index [15:3], table bit [2], RPL [1:0] |
| desc_present_i | input | 1 | Descriptor present bit |
| desc_codedata_i | input | 1 | 1 for code/data descriptor, 0 for system descriptor |
| desc_exec_i | input | 1 | Executable segment |
| desc_read_i | input | 1 | Readable segment |
| desc_write_i | input | 1 | Writable segment |
| desc_conform_i | input | 1 | Conforming code segment |
| desc_dpl_i | input | 2 | Descriptor privilege level |
| gdt_limit_i | input | 16 | Global table limit in bytes |
| ldt_limit_i | input | 16 | Local table limit in bytes |
| cpl_i | input | 2 | Current privilege level |
| task_sw_i | input | 1 | Load is part of a hardware task switch |
| long_mode_i | input | 1 | Long mode active |
| stk_limit_fail_i | input | 1 | Stack access failed its limit check |
| stk_noncanon_i | input | 1 | Stack access at a non-canonical address |
| done_o | output | 1 | Verdict valid this cycle |
| fault_o | output | 1 | Verdict is an exception |
| vector_o | output | 8 | Exception vector, 0 on success |
| err_code_o | output | 16 | Exception error code |

## Verification
Each class is driven with a fully legal descriptor and then with one attribute changed at a time. This separates the present, type and privilege paths and shows that the stack class answers with a different vector than the code and data classes. Conforming and non-conforming code segments are tried with DPL above, equal to and below CPL. Selectors at the exact table-limit boundary and one entry past it are tried in both tables. Loads with several failures at once, and the same failure in plain, legacy task-switch and long-mode contexts, expose the ranking of the checks and the vector-10 substitution.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [1:0] {
    RC_CODE  = 2'd0,
    RC_STACK = 2'd1,
    RC_DATA  = 2'd2
  } rclass_e;

  localparam logic [7:0] VEC_NONE = 8'd0;
  localparam logic [7:0] VEC_TS   = 8'd10;
  localparam logic [7:0] VEC_NP   = 8'd11;
  localparam logic [7:0] VEC_SS   = 8'd12;
  localparam logic [7:0] VEC_GP   = 8'd13;

  typedef struct packed {
    logic       present;
    logic       is_cd;
    logic       exec;
    logic       readable;
    logic       writable;
    logic       conform;
    logic [1:0] dpl;
  } desc_t;

endpackage

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
  parameter int SEL_W = 16,
  parameter int LIM_W = 16
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [LIM_W-1:0] gdt_limit_i,
  input  logic [LIM_W-1:0] ldt_limit_i,
  output logic             out_of_range_o
);
  localparam int CMP_W = (SEL_W > LIM_W) ? SEL_W : LIM_W;

  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] limit;

  // last byte of the 8-byte entry
  assign last_byte = CMP_W'({sel_i[SEL_W-1:3], 3'b111});
  assign limit     = sel_i[2] ? CMP_W'(ldt_limit_i) : CMP_W'(gdt_limit_i);

  assign out_of_range_o = last_byte > limit;
endmodule

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
  import seg_chk_pkg::*;
(
  input  logic [1:0] rclass_i,
  input  desc_t      desc_i,
  input  logic [1:0] cpl_i,
  input  logic [1:0] rpl_i,
  output logic       rights_fail_o
);
  logic code_type_bad, code_priv_bad;
  logic stk_type_bad, stk_priv_bad;
  logic data_type_bad;

  assign code_type_bad = !desc_i.is_cd || !desc_i.exec;
  assign code_priv_bad = desc_i.conform ? (desc_i.dpl > cpl_i) : (desc_i.dpl != cpl_i);
  assign stk_type_bad  = !desc_i.is_cd || desc_i.exec || !desc_i.writable;
  assign stk_priv_bad  = (desc_i.dpl != cpl_i) || (rpl_i != cpl_i);
  assign data_type_bad = !desc_i.is_cd || !desc_i.readable;

  always_comb begin
    unique case (rclass_i)
      RC_CODE:  rights_fail_o = code_type_bad || code_priv_bad;
      RC_STACK: rights_fail_o = stk_type_bad || stk_priv_bad;
      default:  rights_fail_o = data_type_bad;
    endcase
  end
endmodule

// File: rtl/seg_fault_arb.sv
module seg_fault_arb
  import seg_chk_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int VEC_W = 8
) (
  input  logic [1:0]       rclass_i,
  input  logic [SEL_W-1:2] sel_hi_i,
  input  logic             null_sel_i,
  input  logic             out_of_range_i,
  input  logic             present_i,
  input  logic             rights_fail_i,
  input  logic             ts_ctx_i,
  input  logic             stk_fail_i,
  output logic             fault_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [SEL_W-1:0] code_o
);
  logic             is_data;
  logic [VEC_W-1:0] prot_vec;
  logic [SEL_W-1:0] sel_code;

  assign is_data  = rclass_i[1];
  assign prot_vec = ts_ctx_i ? VEC_W'(VEC_TS) : VEC_W'(VEC_GP);
  assign sel_code = {sel_hi_i, 2'b00};

  // ranking: null > range > present > rights > stack status
  always_comb begin
    fault_o  = 1'b1;
    vector_o = VEC_W'(VEC_NONE);
    code_o   = '0;
    if (null_sel_i) begin
      if (is_data) fault_o = 1'b0;
      else         vector_o = VEC_W'(VEC_GP);
    end else if (out_of_range_i) begin
      vector_o = prot_vec;
      code_o   = sel_code;
    end else if (!present_i) begin
      vector_o = (rclass_i == RC_STACK) ? VEC_W'(VEC_SS) : VEC_W'(VEC_NP);
      code_o   = sel_code;
    end else if (rights_fail_i) begin
      vector_o = prot_vec;
      code_o   = sel_code;
    end else if (stk_fail_i) begin
      vector_o = VEC_W'(VEC_SS);
    end else begin
      fault_o = 1'b0;
    end
  end
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
  import seg_chk_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int LIM_W = 16,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       rclass_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             desc_present_i,
  input  logic             desc_codedata_i,
  input  logic             desc_exec_i,
  input  logic             desc_read_i,
  input  logic             desc_write_i,
  input  logic             desc_conform_i,
  input  logic [1:0]       desc_dpl_i,
  input  logic [LIM_W-1:0] gdt_limit_i,
  input  logic [LIM_W-1:0] ldt_limit_i,
  input  logic [1:0]       cpl_i,
  input  logic             task_sw_i,
  input  logic             long_mode_i,
  input  logic             stk_limit_fail_i,
  input  logic             stk_noncanon_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [SEL_W-1:0] err_code_o
);
  desc_t            desc;
  logic             null_sel, out_of_range, rights_fail, ts_ctx;
  logic             fault_d;
  logic [VEC_W-1:0] vector_d;
  logic [SEL_W-1:0] code_d;

  assign desc = '{present:  desc_present_i,
                  is_cd:    desc_codedata_i,
                  exec:     desc_exec_i,
                  readable: desc_read_i,
                  writable: desc_write_i,
                  conform:  desc_conform_i,
                  dpl:      desc_dpl_i};

  assign null_sel = (sel_i[SEL_W-1:2] == '0);
  // hardware task switching does not exist in long mode
  assign ts_ctx   = task_sw_i && !long_mode_i;

  seg_limit_chk #(.SEL_W(SEL_W), .LIM_W(LIM_W)) i_limit (
    .sel_i          (sel_i),
    .gdt_limit_i    (gdt_limit_i),
    .ldt_limit_i    (ldt_limit_i),
    .out_of_range_o (out_of_range)
  );

  seg_rights_chk i_rights (
    .rclass_i      (rclass_i),
    .desc_i        (desc),
    .cpl_i         (cpl_i),
    .rpl_i         (sel_i[1:0]),
    .rights_fail_o (rights_fail)
  );

  seg_fault_arb #(.SEL_W(SEL_W), .VEC_W(VEC_W)) i_arb (
    .rclass_i       (rclass_i),
    .sel_hi_i       (sel_i[SEL_W-1:2]),
    .null_sel_i     (null_sel),
    .out_of_range_i (out_of_range),
    .present_i      (desc.present),
    .rights_fail_i  (rights_fail),
    .ts_ctx_i       (ts_ctx),
    .stk_fail_i     (stk_limit_fail_i || stk_noncanon_i),
    .fault_o        (fault_d),
    .vector_o       (vector_d),
    .code_o         (code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      vector_o   <= '0;
      err_code_o <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        fault_o    <= fault_d;
        vector_o   <= vector_d;
        err_code_o <= code_d;
      end else begin
        fault_o    <= 1'b0;
        vector_o   <= '0;
        err_code_o <= '0;
      end
    end
  end
endmodule

// File: rtl/seg_load_checker_sva.sv
module seg_load_checker_sva #(
  parameter int SEL_W = 16,
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       rclass_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             long_mode_i,
  input logic             done_o,
  input logic             fault_o,
  input logic [VEC_W-1:0] vector_o,
  input logic [SEL_W-1:0] err_code_o
);
  p_done_after_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  p_no_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);

  p_success_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (vector_o == '0 && err_code_o == '0));

  p_code_low_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_code_o[1:0] == 2'b00));

  p_vector_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (vector_o >= VEC_W'(10) && vector_o <= VEC_W'(13)));

  p_null_ctl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !rclass_i[1] && sel_i[SEL_W-1:2] == '0)
      |=> (fault_o && vector_o == VEC_W'(13) && err_code_o == '0));

  p_null_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rclass_i[1] && sel_i[SEL_W-1:2] == '0) |=> !fault_o);

  p_no_ts_long_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && long_mode_i) |=> (vector_o != VEC_W'(10)));
endmodule

bind seg_load_checker seg_load_checker_sva #(.SEL_W(SEL_W), .VEC_W(VEC_W)) i_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .rclass_i    (rclass_i),
  .sel_i       (sel_i),
  .long_mode_i (long_mode_i),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .vector_o    (vector_o),
  .err_code_o  (err_code_o)
);

// File: tb/test_seg_load_checker.sv
module test_seg_load_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  rclass = 2'd0;
  logic [15:0] sel = '0;
  logic        d_p = 1'b0, d_cd = 1'b0, d_x = 1'b0, d_r = 1'b0, d_w = 1'b0, d_c = 1'b0;
  logic [1:0]  d_dpl = '0;
  logic [15:0] gdt_lim = 16'h00FF, ldt_lim = 16'h003F;
  logic [1:0]  cpl = '0;
  logic        tsw = 1'b0, lmode = 1'b0, s_lim = 1'b0, s_nc = 1'b0;
  logic        done, fault;
  logic [7:0]  vec;
  logic [15:0] code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seg_load_checker i_seg_load_checker (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .rclass_i(rclass), .sel_i(sel),
    .desc_present_i(d_p), .desc_codedata_i(d_cd), .desc_exec_i(d_x),
    .desc_read_i(d_r), .desc_write_i(d_w), .desc_conform_i(d_c), .desc_dpl_i(d_dpl),
    .gdt_limit_i(gdt_lim), .ldt_limit_i(ldt_lim), .cpl_i(cpl), .task_sw_i(tsw),
    .long_mode_i(lmode), .stk_limit_fail_i(s_lim), .stk_noncanon_i(s_nc),
    .done_o(done), .fault_o(fault), .vector_o(vec), .err_code_o(code)
  );

  task automatic check(input string req, input logic e_done, input logic e_fault,
                       input logic [7:0] e_vec, input logic [15:0] e_code);
    checks++;
    if (done !== e_done || fault !== e_fault || vec !== e_vec || code !== e_code) begin
      errors++;
      $display("FAIL %s: got done=%0b fault=%0b vec=%0d code=%h, exp done=%0b fault=%0b vec=%0d code=%h",
               req, done, fault, vec, code, e_done, e_fault, e_vec, e_code);
    end
  endtask

  // legal descriptor for the given class, plain legacy context
  task automatic base(input logic [1:0] cls, input logic [15:0] s, input logic [1:0] pl);
    rclass = cls; sel = s; cpl = pl; d_dpl = pl;
    d_p = 1'b1; d_cd = 1'b1; d_c = 1'b0;
    d_x = (cls == 2'd0); d_r = 1'b1; d_w = (cls != 2'd0);
    tsw = 1'b0; lmode = 1'b0; s_lim = 1'b0; s_nc = 1'b0;
    gdt_lim = 16'h00FF; ldt_lim = 16'h003F;
  endtask

  task automatic fire(input string req, input logic e_fault, input logic [7:0] e_vec,
                      input logic [15:0] e_code);
    @(negedge clk) valid = 1'b1;
    @(negedge clk) valid = 1'b0;
    check(req, 1'b1, e_fault, e_vec, e_code);
  endtask

  task automatic t_reset;
    check("R1", 1'b0, 1'b0, 8'd0, 16'h0000);
  endtask

  task automatic t_idle;
    base(2'd0, 16'h0018, 2'd0);
    repeat (3) begin
      @(negedge clk);
      check("R2 idle", 1'b0, 1'b0, 8'd0, 16'h0000);
    end
  endtask

  task automatic t_code;
    base(2'd0, 16'h0018, 2'd0); fire("R6 cs ok", 1'b0, 8'd0, 16'h0000);
    base(2'd0, 16'h0018, 2'd0); d_dpl = 2'd1; fire("R6 nonconf dpl>cpl", 1'b1, 8'd13, 16'h0018);
    base(2'd0, 16'h001A, 2'd2); d_dpl = 2'd1; fire("R6 nonconf dpl<cpl", 1'b1, 8'd13, 16'h0018);
    base(2'd0, 16'h001A, 2'd2); d_c = 1'b1; d_dpl = 2'd0; fire("R6 conf dpl<cpl", 1'b0, 8'd0, 16'h0000);
    base(2'd0, 16'h001A, 2'd2); d_c = 1'b1; d_dpl = 2'd3; fire("R6 conf dpl>cpl", 1'b1, 8'd13, 16'h0018);
    base(2'd0, 16'h0018, 2'd0); d_x = 1'b0; fire("R6 not exec", 1'b1, 8'd13, 16'h0018);
  endtask

  task automatic t_stack;
    base(2'd1, 16'h0023, 2'd3); fire("R7 ss ok", 1'b0, 8'd0, 16'h0000);
    base(2'd1, 16'h0022, 2'd3); d_dpl = 2'd3; fire("R7 rpl!=cpl", 1'b1, 8'd13, 16'h0020);
    base(2'd1, 16'h0023, 2'd3); d_dpl = 2'd2; fire("R7 dpl!=cpl", 1'b1, 8'd13, 16'h0020);
    base(2'd1, 16'h0023, 2'd3); d_w = 1'b0; fire("R7 not writable", 1'b1, 8'd13, 16'h0020);
  endtask

  task automatic t_data;
    base(2'd2, 16'h0030, 2'd0); fire("R8 ds ok", 1'b0, 8'd0, 16'h0000);
    base(2'd3, 16'h0030, 2'd0); d_r = 1'b0; fire("R8 not readable", 1'b1, 8'd13, 16'h0030);
    base(2'd2, 16'h0030, 2'd0); d_cd = 1'b0; fire("R8 system desc", 1'b1, 8'd13, 16'h0030);
  endtask

  task automatic t_null;
    base(2'd0, 16'h0003, 2'd0); fire("R3 null cs", 1'b1, 8'd13, 16'h0000);
    base(2'd1, 16'h0000, 2'd0); d_p = 1'b0; fire("R3 null ss", 1'b1, 8'd13, 16'h0000);
    base(2'd2, 16'h0001, 2'd0); d_p = 1'b0; d_r = 1'b0; fire("R3 null ds", 1'b0, 8'd0, 16'h0000);
  endtask

  task automatic t_limit;
    base(2'd2, 16'h00F8, 2'd0); fire("R4 gdt edge", 1'b0, 8'd0, 16'h0000);
    base(2'd2, 16'h0100, 2'd0); d_p = 1'b0; fire("R4 gdt past", 1'b1, 8'd13, 16'h0100);
    base(2'd2, 16'h003C, 2'd0); fire("R4 ldt edge", 1'b0, 8'd0, 16'h0000);
    base(2'd2, 16'h0044, 2'd0); fire("R4 ldt past", 1'b1, 8'd13, 16'h0044);
    base(2'd0, 16'h0100, 2'd0); tsw = 1'b1; fire("R4 past in task", 1'b1, 8'd10, 16'h0100);
  endtask

  task automatic t_present;
    base(2'd0, 16'h002B, 2'd3); d_dpl = 2'd3; d_p = 1'b0; fire("R5 cs np", 1'b1, 8'd11, 16'h0028);
    base(2'd1, 16'h0023, 2'd3); d_p = 1'b0; fire("R5 ss np", 1'b1, 8'd12, 16'h0020);
    base(2'd2, 16'h0030, 2'd0); d_p = 1'b0; d_r = 1'b0; fire("R5 ds np outranks", 1'b1, 8'd11, 16'h0030);
    base(2'd0, 16'h0006, 2'd2); d_p = 1'b0; tsw = 1'b1; fire("R5 np task R11 ti", 1'b1, 8'd11, 16'h0004);
  endtask

  task automatic t_context;
    base(2'd0, 16'h0018, 2'd0); d_dpl = 2'd1; tsw = 1'b1; fire("R9 task switch", 1'b1, 8'd10, 16'h0018);
    base(2'd0, 16'h0018, 2'd0); d_dpl = 2'd1; tsw = 1'b1; lmode = 1'b1; fire("R9 long mode", 1'b1, 8'd13, 16'h0018);
    base(2'd1, 16'h0023, 2'd3); d_w = 1'b0; tsw = 1'b1; fire("R9 ss task", 1'b1, 8'd10, 16'h0020);
  endtask

  task automatic t_stack_status;
    base(2'd1, 16'h0023, 2'd3); s_lim = 1'b1; fire("R10 limit", 1'b1, 8'd12, 16'h0000);
    base(2'd2, 16'h0030, 2'd0); s_nc = 1'b1; fire("R10 noncanon", 1'b1, 8'd12, 16'h0000);
    base(2'd1, 16'h0023, 2'd3); s_lim = 1'b1; d_dpl = 2'd0; fire("R10 ranked last", 1'b1, 8'd13, 16'h0020);
  endtask

  initial begin
    fork
      begin
        #3 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_code();
        t_stack();
        t_data();
        t_null();
        t_limit();
        t_present();
        t_context();
        t_stack_status();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule